// File: doc/BRIEF.md
# Priority-Ordered Circular Queue Engine

This block moves one process record from one queue to another. The queues and the records live in a word-addressed process memory. Every queue is a circular singly linked list. A queue word names the tail of the list, and the tail's link points back to the head. The destination list is kept in descending priority order, and processes of equal priority stay in first-in, first-out order.

A command gives a process index, a destination queue address, and either a source queue address or a flag saying the source queue is unknown. The engine unlinks the process from its current list. It then walks the destination list and splices the process in at the point that priority order requires.

When the source is unknown, the engine leaves every queue word alone. Instead it records the process's former successor in the process's flags word, so that later software can repair the list.

All memory traffic goes through one synchronous port. A read returns its data one cycle after the read strobe. A write lands at the clock edge. Every stored word is updated by read-modify-write, so each write changes only the index field.

Top module: `qmv_requeue`

## Requirements
- R1: Layout. Bits are numbered from the LSB. An index field occupies bits [11:2] of a queue word, of a link word (the next process) and of a flags word (the cleanup index), and an index of zero means empty or none. A link word holds the priority in bits [14:12]. For process index p, the link word is at address 4*p and the flags word is at address 4*p+1.
- R2: A command is taken on `start_i` while `busy_o` is low. `busy_o` is high from the next cycle until the cycle after `done_o`, and `done_o` is a single-cycle pulse.
- R3: A process whose next field points to itself is removed without a list walk. With a source queue given, that queue's tail field becomes zero.
- R4: With a source queue given, the predecessor found by walking from the queue tail is relinked to the removed process's successor. If the removed process was the tail, the tail field becomes that predecessor.
- R5: With an unknown source, the walk starts at the process itself and no queue word is written. The process's former next index is written to the cleanup field of its flags word; for a self-linked process this is its own index.
- R6: Insertion into an empty destination links the process to itself and makes it the tail.
- R7: If the destination tail's priority is greater than or equal to the process's priority, the process is appended after the tail and becomes the new tail.
- R8: Otherwise the engine scans from the head and places the process just before the first entry whose priority is lower than its own. The tail is left unchanged.
- R9: Every written word keeps all bits outside [11:2] as they were read.
- R10: The memory port never reads and writes in the same cycle. Read data is consumed only in the cycle after its read strobe.
- R11: The source and destination may be the same queue; the process is then re-placed according to its current priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken when idle |
| src_nil_i | input | 1 | Source queue unknown |
| src_q_i | input | AW | Source queue word address |
| dst_q_i | input | AW | Destination queue word address |
| psb_i | input | 10 | Index of the process to move |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the strobe |

## Verification
The hardest state to reach from the ports is a removal with an unknown source from the middle of a long list. Here the walk must go all the way around the ring from the process back to its predecessor, while the stale queue word stays valid. A second hard case is a re-placement after a priority change, where the scan stops inside the list rather than at either end.

The stimulus first builds a list of mixed priorities purely through unknown-source moves of self-linked processes. It then issues directed head, middle and tail removals. After that, a long random mix allows an unknown source only when the chosen process is not a tail, and it occasionally changes a priority in memory before a same-queue move.

// File: rtl/qmv_pkg.sv
package qmv_pkg;
  localparam int WORD_W  = 16;
  localparam int IDX_W   = 10;
  localparam int IDX_LSB = 2;
  localparam int HDL_W   = IDX_W + IDX_LSB;
  localparam int PRI_LSB = 12;
  localparam int PRI_W   = 3;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HDL_W-1:0]  hdl_t;
  typedef logic [PRI_W-1:0]  pri_t;

  localparam word_t IDX_MASK = word_t'(((1 << IDX_W) - 1) << IDX_LSB);

  typedef enum logic [4:0] {
    S_IDLE, S_RL_RD, S_RL_CK, S_ST_RD, S_ST_CK, S_WK_RD, S_WK_CK,
    S_CL_RD, S_CL_WR, S_SQ_RD, S_SQ_CK, S_DQ_RD, S_DQ_CK, S_PL_RD,
    S_PL_CK, S_TL_RD, S_TL_CK, S_SC_RD, S_SC_CK, S_LK_WR, S_PV_WR,
    S_DQ_WR, S_DONE
  } st_t;

  // index field of a word, expressed as a handle (4 * index)
  function automatic hdl_t hdl_of(word_t w);
    return {w[IDX_LSB+IDX_W-1:IDX_LSB], {IDX_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/qmv_link_decode.sv
module qmv_link_decode
  import qmv_pkg::*;
(
  input  word_t word_i,
  output word_t word_o,
  output hdl_t  hdl_o,
  output pri_t  pri_o
);
  assign word_o = word_i;
  assign hdl_o  = hdl_of(word_i);
  assign pri_o  = word_i[PRI_LSB+PRI_W-1:PRI_LSB];
endmodule

// File: rtl/qmv_field_merge.sv
module qmv_field_merge
  import qmv_pkg::*;
(
  input  word_t base_i,
  input  hdl_t  put_i,
  output word_t word_o
);
  word_t put_w;
  assign put_w  = word_t'(put_i);
  assign word_o = (base_i & ~IDX_MASK) | (put_w & IDX_MASK);
endmodule

// File: rtl/qmv_seq.sv
module qmv_seq
  import qmv_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           src_nil_i,
  input  logic [AW-1:0]  src_q_i,
  input  logic [AW-1:0]  dst_q_i,
  input  logic [IDX_W-1:0] psb_i,
  input  word_t          rd_word_i,
  input  hdl_t           rd_hdl_i,
  input  pri_t           rd_pri_i,
  output logic           re_o,
  output logic           we_o,
  output logic [AW-1:0]  addr_o,
  output word_t          base_o,
  output hdl_t           put_o,
  output logic           busy_o,
  output logic           done_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  st_t           st;
  logic          nil_q, upd_tail;
  logic [AW-1:0] srcq, dstq;
  hdl_t          psb_h, old_nxt, prev_h, tail_h;
  word_t         prev_w, dq_w, my_lnk;
  pri_t          my_pri;
  logic [AW-1:0] psb_a, prev_a, tail_a, scan_a;
  logic          rd_is_me;

  assign psb_a    = AW'(psb_h);
  assign prev_a   = AW'(prev_h);
  assign tail_a   = AW'(tail_h);
  assign scan_a   = AW'(hdl_of(prev_w));
  assign rd_is_me = (rd_hdl_i == psb_h);
  assign busy_o   = (st != S_IDLE);
  assign done_o   = (st == S_DONE);

  always_comb begin
    re_o = 1'b0; we_o = 1'b0; addr_o = '0; base_o = '0; put_o = '0;
    unique case (st)
      S_RL_RD, S_PL_RD: begin re_o = 1'b1; addr_o = psb_a; end
      S_ST_RD, S_SQ_RD: begin re_o = 1'b1; addr_o = srcq; end
      S_WK_RD: begin re_o = 1'b1; addr_o = prev_a; end
      S_WK_CK: if (rd_is_me) begin
        we_o = 1'b1; addr_o = prev_a; base_o = rd_word_i; put_o = old_nxt;
      end
      S_CL_RD: begin re_o = 1'b1; addr_o = psb_a + ONE; end
      S_CL_WR: begin
        we_o = 1'b1; addr_o = psb_a + ONE; base_o = rd_word_i; put_o = old_nxt;
      end
      S_SQ_CK: if (rd_is_me) begin
        we_o = 1'b1; addr_o = srcq; base_o = rd_word_i; put_o = prev_h;
      end
      S_DQ_RD: begin re_o = 1'b1; addr_o = dstq; end
      S_PL_CK: if (tail_h == '0) begin
        we_o = 1'b1; addr_o = psb_a; base_o = rd_word_i; put_o = psb_h;
      end
      S_TL_RD: begin re_o = 1'b1; addr_o = tail_a; end
      S_SC_RD: begin re_o = 1'b1; addr_o = scan_a; end
      S_LK_WR: begin
        we_o = 1'b1; addr_o = psb_a; base_o = my_lnk; put_o = hdl_of(prev_w);
      end
      S_PV_WR: begin
        we_o = 1'b1; addr_o = prev_a; base_o = prev_w; put_o = psb_h;
      end
      S_DQ_WR: begin
        we_o = 1'b1; addr_o = dstq; base_o = dq_w; put_o = psb_h;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; nil_q <= 1'b0; upd_tail <= 1'b0;
      srcq <= '0; dstq <= '0; psb_h <= '0; old_nxt <= '0; prev_h <= '0;
      tail_h <= '0; prev_w <= '0; dq_w <= '0; my_lnk <= '0; my_pri <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start_i) begin
          nil_q <= src_nil_i; srcq <= src_q_i; dstq <= dst_q_i;
          psb_h <= {psb_i, {IDX_LSB{1'b0}}}; upd_tail <= 1'b0; st <= S_RL_RD;
        end
        S_RL_RD: st <= S_RL_CK;
        S_RL_CK: begin
          old_nxt <= rd_hdl_i;
          if (rd_is_me) begin
            prev_h <= '0;
            st     <= nil_q ? S_CL_RD : S_SQ_RD;
          end else if (nil_q) begin
            prev_h <= psb_h; st <= S_WK_RD;   // walk around the ring from itself
          end else st <= S_ST_RD;
        end
        S_ST_RD: st <= S_ST_CK;
        S_ST_CK: begin prev_h <= rd_hdl_i; st <= S_WK_RD; end
        S_WK_RD: st <= S_WK_CK;
        S_WK_CK: if (rd_is_me) st <= nil_q ? S_CL_RD : S_SQ_RD;
                 else begin prev_h <= rd_hdl_i; st <= S_WK_RD; end
        S_CL_RD: st <= S_CL_WR;
        S_CL_WR: st <= S_DQ_RD;
        S_SQ_RD: st <= S_SQ_CK;
        S_SQ_CK: st <= S_DQ_RD;
        S_DQ_RD: st <= S_DQ_CK;
        S_DQ_CK: begin dq_w <= rd_word_i; tail_h <= rd_hdl_i; st <= S_PL_RD; end
        S_PL_RD: st <= S_PL_CK;
        S_PL_CK: begin
          my_lnk <= rd_word_i; my_pri <= rd_pri_i;
          st <= (tail_h == '0) ? S_DQ_WR : S_TL_RD;
        end
        S_TL_RD: st <= S_TL_CK;
        S_TL_CK: begin
          prev_h <= tail_h; prev_w <= rd_word_i;
          if (rd_pri_i >= my_pri) begin upd_tail <= 1'b1; st <= S_LK_WR; end
          else st <= S_SC_RD;
        end
        S_SC_RD: st <= S_SC_CK;
        S_SC_CK: if (rd_pri_i < my_pri) st <= S_LK_WR;
                 else begin prev_h <= hdl_of(prev_w); prev_w <= rd_word_i; st <= S_SC_RD; end
        S_LK_WR: st <= S_PV_WR;
        S_PV_WR: st <= upd_tail ? S_DQ_WR : S_DONE;
        S_DQ_WR: st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic in_ck;
  assign in_ck = (st == S_RL_CK) || (st == S_ST_CK) || (st == S_WK_CK) ||
                 (st == S_SQ_CK) || (st == S_DQ_CK) || (st == S_PL_CK) ||
                 (st == S_TL_CK) || (st == S_SC_CK) || (st == S_CL_WR);

  // read data is only consumed one cycle after its strobe
  assert_rd_before_use_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ck |-> $past(re_o));
endmodule

// File: rtl/qmv_requeue.sv
module qmv_requeue
  import qmv_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              src_nil_i,
  input  logic [AW-1:0]     src_q_i,
  input  logic [AW-1:0]     dst_q_i,
  input  logic [IDX_W-1:0]  psb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  word_t rd_word, wr_base;
  hdl_t  rd_hdl, wr_put;
  pri_t  rd_pri;

  qmv_link_decode u_dec (
    .word_i(mem_rdata_i), .word_o(rd_word), .hdl_o(rd_hdl), .pri_o(rd_pri)
  );

  qmv_seq #(.AW(AW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .src_nil_i(src_nil_i),
    .src_q_i(src_q_i), .dst_q_i(dst_q_i), .psb_i(psb_i),
    .rd_word_i(rd_word), .rd_hdl_i(rd_hdl), .rd_pri_i(rd_pri),
    .re_o(mem_re_o), .we_o(mem_we_o), .addr_o(mem_addr_o),
    .base_o(wr_base), .put_o(wr_put), .busy_o(busy_o), .done_o(done_o)
  );

  qmv_field_merge u_mrg (
    .base_i(wr_base), .put_i(wr_put), .word_o(mem_wdata_o)
  );

  assert_port_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_re_o || mem_we_o));
endmodule

// File: tb/tb_qmv_requeue.sv
`timescale 1ns/1ps
module tb_qmv_requeue;
  localparam int AW = 12;
  localparam int QB = 'h400;
  localparam int NQ = 4;
  localparam logic [15:0] FMASK = 16'h0FFC;
  localparam logic [15:0] QPAT  = 16'h8003;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 1'b0, nil = 1'b0;
  logic [AW-1:0] srcq = '0, dstq = '0;
  logic [9:0] psb = '0;
  logic busy, done, re, we;
  logic [AW-1:0] addr;
  logic [15:0] wdata, rdata;
  logic [15:0] ram [0:4095];
  logic tb_we = 1'b0;
  logic [AW-1:0] tb_a = '0;
  logic [15:0] tb_d = '0;

  int nvec = 0, nbad = 0, cyc = 0;
  int qm[NQ][$];
  int pr[16];
  logic [15:0] lo_m[16], fl_m[16];
  bit free_m[16];

  always #2.5 clk = ~clk;

  qmv_requeue #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .src_nil_i(nil),
    .src_q_i(srcq), .dst_q_i(dstq), .psb_i(psb), .busy_o(busy), .done_o(done),
    .mem_re_o(re), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    if (tb_we) ram[tb_a] <= tb_d;
    if (re) rdata <= ram[addr];
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_ni) chk(!(re && we), "R10", "read and write together", 1, 0);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nbad++;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic poke(int a, logic [15:0] d);
    @(negedge clk); tb_we = 1'b1; tb_a = AW'(a); tb_d = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  function automatic int idx_of(logic [15:0] w);
    return int'((w & FMASK) >> 2);
  endfunction

  task automatic check_all(string tag);
    for (int q = 0; q < NQ; q++) begin
      int tail = idx_of(ram[QB+q]);
      int n = qm[q].size();
      int exp = (n == 0) ? 0 : qm[q][n-1];
      chk(tail == exp, tag, "queue tail", tail, exp);
      chk((ram[QB+q] & ~FMASK) == QPAT, "R9", "queue word spare bits", int'(ram[QB+q]), int'(QPAT));
      if (n > 0) begin
        int cur = idx_of(ram[4*tail]);
        int bad = 0, bact = 0, bexp = 0;
        for (int i = 0; i < n; i++) begin
          if (cur != qm[q][i] && bad == 0) begin bad = 1; bact = cur; bexp = qm[q][i]; end
          cur = idx_of(ram[4*cur]);
        end
        if (bad == 0 && cur != qm[q][0]) begin bad = 1; bact = cur; bexp = qm[q][0]; end
        chk(bad == 0, tag, "list order", bact, bexp);
      end
    end
    for (int p = 1; p < 16; p++) begin
      chk((ram[4*p] & ~FMASK) == lo_m[p], "R9", "link word spare bits (R1 layout)",
          int'(ram[4*p] & ~FMASK), int'(lo_m[p]));
      chk(ram[4*p+1] == fl_m[p], "R5", "flags word", int'(ram[4*p+1]), int'(fl_m[p]));
    end
  endtask

  task automatic find(int p, output int fq, output int fi);
    fq = -1; fi = -1;
    for (int q = 0; q < NQ; q++)
      for (int i = 0; i < qm[q].size(); i++)
        if (qm[q][i] == p) begin fq = q; fi = i; end
  endtask

  task automatic run_cmd(bit n, int s, int d, int p, string tag);
    int oq, oi, onx, pos, k;
    if (free_m[p]) onx = p;
    else begin
      find(p, oq, oi);
      onx = qm[oq][(oi + 1) % qm[oq].size()];
    end
    if (n) fl_m[p] = (fl_m[p] & ~FMASK) | 16'(onx << 2);
    if (!free_m[p]) qm[oq].delete(oi);
    free_m[p] = 1'b0;
    if (qm[d].size() == 0 || pr[qm[d][qm[d].size()-1]] >= pr[p]) qm[d].push_back(p);
    else begin
      pos = 0;
      while (pr[qm[d][pos]] >= pr[p]) pos++;
      qm[d].insert(pos, p);
    end
    @(negedge clk);
    start = 1'b1; nil = n; srcq = AW'(QB + s); dstq = AW'(QB + d); psb = 10'(p);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    chk(done == 1'b1, "R2", "done pulse seen", int'(done), 1);
    @(negedge clk);
    chk(!busy && !done, "R2", "idle after done", int'(busy), 0);
    check_all(tag);
  endtask

  task automatic reprio(int p, int np);
    pr[p] = np;
    lo_m[p] = (lo_m[p] & ~16'h7000) | 16'(np << 12);
    poke(4*p, (ram[4*p] & ~16'h7000) | 16'(np << 12));
  endtask

  initial begin
    int ip[16] = '{0, 3, 5, 3, 1, 7, 5, 0, 3, 2, 6, 4, 1, 5, 2, 7};
    for (int p = 1; p < 16; p++) begin
      pr[p] = ip[p];
      free_m[p] = 1'b1;
      lo_m[p] = 16'(ip[p] << 12) | (p[0] ? 16'h8000 : 16'h0) |
                (p[1] ? 16'h0002 : 16'h0) | (p[2] ? 16'h0001 : 16'h0);
      fl_m[p] = 16'hB003;
      poke(4*p, lo_m[p] | 16'(p << 2));
      poke(4*p+1, fl_m[p]);
    end
    for (int q = 0; q < NQ; q++) poke(QB+q, QPAT);
    @(negedge clk);
    chk(!busy && !done, "R2", "reset outputs", int'(busy), 0);
    chk(!re && !we, "R10", "reset memory strobes", int'(re), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy && !re && !we, "R2", "idle after reset", int'(busy), 0);

    run_cmd(1, 0, 0, 1, "R6");
    run_cmd(1, 0, 0, 3, "R7");
    run_cmd(1, 0, 0, 2, "R8");
    run_cmd(1, 0, 0, 4, "R7");
    run_cmd(1, 0, 0, 5, "R8");
    run_cmd(1, 0, 0, 6, "R8");
    run_cmd(1, 0, 0, 7, "R7");
    run_cmd(1, 0, 0, 8, "R8");
    run_cmd(0, 0, 1, 7, "R4");
    run_cmd(0, 0, 1, 5, "R4");
    run_cmd(0, 0, 1, 6, "R4");
    run_cmd(1, 0, 2, 2, "R5");
    run_cmd(0, 2, 1, 2, "R3");
    reprio(4, 6);
    run_cmd(0, 0, 0, 4, "R11");
    reprio(1, 2);
    run_cmd(0, 0, 0, 1, "R11");

    for (int it = 0; it < 300; it++) begin
      int p = 1 + int'($urandom % 15);
      int d = int'($urandom % NQ);
      int fq, fi;
      if ($urandom % 5 == 0) reprio(p, int'($urandom % 8));
      if (free_m[p]) run_cmd(1, 0, d, p, "R5");
      else begin
        find(p, fq, fi);
        if (fi != qm[fq].size() - 1 && ($urandom % 2) == 1) run_cmd(1, 0, d, p, "R5");
        else run_cmd(0, fq, d, p, "R8");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule